// File: doc/BRIEF.md
# Multichannel ADC scan sequencer

This block drives an external converter that performs one conversion per request, so that a single frame collects one sample from each of six multiplexed inputs, lowest input first. The converter is requested with a one-cycle start pulse and answers with a one-cycle done strobe that carries its 10-bit result. The sequencer owns the multiplexer select lines, keeps a result register for every input, and publishes a progress count. A downstream reader can therefore pick up each input as soon as its sample has arrived, without waiting for the whole frame.

A frame begins only on an explicit command. After the last input is converted, the sequencer points the multiplexer back at input 0 and waits for the next command. The converter itself, its reference and its calibration are outside this block.

Top module: `adc_scan_seq`

## Requirements
- R1: A synchronous active-high reset sets the progress count to 0 and the mux select to 0, clears every result slot, holds the start output low and leaves the block idle.
- R2: A frame command seen while idle produces, in the next cycle, a start pulse with mux select 0 and progress count 0.
- R3: The start output is high for exactly one cycle per request.
- R4: A done strobe during a scan writes the 10-bit data into the slot of the current progress count, and the count rises by one in the next cycle. Slot k occupies bits [16k+15:16k] of the results bus.
- R5: Inputs are converted in ascending order 0 to 5: after the done for input k < 5, the next cycle shows mux select k+1 together with a new start pulse.
- R6: After the done for input 5, the next cycle shows progress count 6 and mux select 0, and no start pulse follows until a new frame command.
- R7: Each slot is 16 bits wide; the sample sits in bits [9:0] and bits [15:10] are always zero.
- R8: A frame command arriving while a scan is in progress has no effect on the count, the mux select or the start output.
- R9: A done strobe arriving while idle is discarded: the results and the progress count are unchanged.
- R10: Slot k holds the value of the previous frame until the done for input k of the new frame overwrites it, so a reader may take slot k as current once the count exceeds k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frameStart | input | 1 | Request to begin a new frame |
| convDone | input | 1 | One-cycle strobe: conversion finished |
| convData | input | 10 | Conversion result, valid with convDone |
| convStart | output | 1 | One-cycle pulse requesting a conversion |
| muxSel | output | 3 | Multiplexer input select |
| scanIdx | output | 3 | Progress count, 0 to 6 |
| results | output | 96 | Six 16-bit result slots, slot k at bits [16k+15:16k] |

## Verification
A corrupted progress count shows up in the first following cycle as a mux select that differs from the count at a start pulse, or as a sample written into the wrong slot when the next done arrives. A stuck or lost state bit shows up either as a start pulse after the sixth input, visible one cycle after that input's done, or as a frame that never requests its next conversion, which the bench sees as a missing start pulse. Ignored commands and stray strobes are checked by watching the count, the select and every slot in the cycles right after the stimulus.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  // Default channel count and the width of any channel counter.
  localparam int SCAN_CH = 6;
  localparam int IDX_W   = $clog2(SCAN_CH + 1);

  // Control-to-datapath strobes, produced every cycle.
  typedef struct packed {
    logic             capture;   // write convData into slot
    logic [IDX_W-1:0] slot;      // slot to write
    logic             selLoad;   // load a new mux select
    logic [IDX_W-1:0] selValue;  // value to load
    logic             fire;      // request a conversion next cycle
  } seqStrobe_t;

endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = SCAN_CH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frameStart,
  input  logic             convDone,
  output seqStrobe_t       strobe,
  output logic [IDX_W-1:0] scanIdx,
  output logic             convStart
);

  localparam logic [IDX_W-1:0] LAST_CH = IDX_W'(NUM_CH - 1);
  localparam logic [IDX_W-1:0] ZERO_CH = '0;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } seqState_t;

  seqState_t        stateQ, stateD;
  logic [IDX_W-1:0] idxQ, idxD;
  logic             startQ;
  logic             lastCh;

  assign lastCh = (idxQ == LAST_CH);

  // Strobe and next-state generation.
  always_comb begin
    strobe   = '0;
    stateD   = stateQ;
    idxD     = idxQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (frameStart) begin
          strobe.selLoad  = 1'b1;
          strobe.selValue = ZERO_CH;
          strobe.fire     = 1'b1;
          idxD            = ZERO_CH;
          stateD          = ST_CONV;
        end
      end
      ST_CONV: begin
        if (convDone) begin
          strobe.capture = 1'b1;
          strobe.slot    = idxQ;
          strobe.selLoad = 1'b1;
          idxD           = idxQ + 1'b1;
          if (lastCh) begin
            strobe.selValue = ZERO_CH;
            strobe.fire     = 1'b0;
            stateD          = ST_IDLE;
          end else begin
            strobe.selValue = idxQ + 1'b1;
            strobe.fire     = 1'b1;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      idxQ   <= ZERO_CH;
      startQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      idxQ   <= idxD;
      startQ <= strobe.fire;
    end
  end

  assign scanIdx   = idxQ;
  assign convStart = startQ;

endmodule

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = SCAN_CH,
  parameter int RES_W  = 10,
  parameter int SLOT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  seqStrobe_t               strobe,
  input  logic [RES_W-1:0]         convData,
  output logic [IDX_W-1:0]         muxSel,
  output logic [NUM_CH*SLOT_W-1:0] results
);

  localparam int PAD_W = SLOT_W - RES_W;

  logic [IDX_W-1:0] selQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      selQ <= '0;
    end else if (strobe.selLoad) begin
      selQ <= strobe.selValue;
    end
  end

  assign muxSel = selQ;

  // One result register per channel.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic [SLOT_W-1:0] slotQ;
    logic              hit;

    assign hit = strobe.capture && (strobe.slot == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        slotQ <= '0;
      end else if (hit) begin
        slotQ <= {{PAD_W{1'b0}}, convData};
      end
    end

    assign results[g*SLOT_W +: SLOT_W] = slotQ;
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = SCAN_CH,
  parameter int RES_W  = 10,
  parameter int SLOT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frameStart,
  input  logic                     convDone,
  input  logic [RES_W-1:0]         convData,
  output logic                     convStart,
  output logic [IDX_W-1:0]         muxSel,
  output logic [IDX_W-1:0]         scanIdx,
  output logic [NUM_CH*SLOT_W-1:0] results
);

  seqStrobe_t strobe;

  adc_scan_ctrl #(
    .NUM_CH(NUM_CH)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .frameStart(frameStart),
    .convDone  (convDone),
    .strobe    (strobe),
    .scanIdx   (scanIdx),
    .convStart (convStart)
  );

  adc_scan_dp #(
    .NUM_CH(NUM_CH),
    .RES_W (RES_W),
    .SLOT_W(SLOT_W)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .convData(convData),
    .muxSel  (muxSel),
    .results (results)
  );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = SCAN_CH,
  parameter int RES_W  = 10,
  parameter int SLOT_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     frameStart,
  input logic                     convDone,
  input logic [RES_W-1:0]         convData,
  input logic                     convStart,
  input logic [IDX_W-1:0]         muxSel,
  input logic [IDX_W-1:0]         scanIdx,
  input logic [NUM_CH*SLOT_W-1:0] results
);

  localparam logic [IDX_W-1:0] DONE_IDX = IDX_W'(NUM_CH);

  // A conversion has been requested and not yet answered.
  logic pending;
  always_ff @(posedge clk) begin
    if (rst)            pending <= 1'b0;
    else if (convStart) pending <= 1'b1;
    else if (convDone)  pending <= 1'b0;
  end

  assert_start_single_R3: assert property (@(posedge clk) disable iff (rst)
    convStart |=> !convStart);

  assert_start_on_idx_R5: assert property (@(posedge clk) disable iff (rst)
    convStart |-> (muxSel == scanIdx) && (scanIdx < DONE_IDX));

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (rst)
    scanIdx <= DONE_IDX);

  assert_park_mux_R6: assert property (@(posedge clk) disable iff (rst)
    (scanIdx == DONE_IDX) |-> (muxSel == '0));

  assert_no_start_after_last_R6: assert property (@(posedge clk) disable iff (rst)
    (scanIdx == DONE_IDX && !frameStart) |=> !convStart);

  assert_busy_ignores_frame_R8: assert property (@(posedge clk) disable iff (rst)
    (pending && !convDone) |=> !convStart && $stable(scanIdx) && $stable(muxSel));

  assert_idle_ignores_done_R9: assert property (@(posedge clk) disable iff (rst)
    (!pending && !convStart && !frameStart) |=> $stable(results) && $stable(scanIdx));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_pad_zero_R7: assert property (@(posedge clk) disable iff (rst)
      results[g*SLOT_W+RES_W +: SLOT_W-RES_W] == '0);

    assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
      (pending && convDone && scanIdx == IDX_W'(g)) |=>
        (results[g*SLOT_W +: RES_W] == $past(convData)) && (scanIdx == IDX_W'(g+1)));
  end

endmodule

bind adc_scan_seq adc_scan_seq_chk #(
  .NUM_CH(NUM_CH),
  .RES_W (RES_W),
  .SLOT_W(SLOT_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .frameStart(frameStart),
  .convDone  (convDone),
  .convData  (convData),
  .convStart (convStart),
  .muxSel    (muxSel),
  .scanIdx   (scanIdx),
  .results   (results)
);

// File: tb/adc_scan_seq_tb_top.sv
`timescale 1ns/1ps
module adc_scan_seq_tb_top;

  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst;
  logic        frameStart;
  logic        convDone;
  logic [9:0]  convData;
  logic        convStart;
  logic [2:0]  muxSel;
  logic [2:0]  scanIdx;
  logic [95:0] results;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [15:0] model [NCH];

  always #4 clk = ~clk;

  adc_scan_seq dut_i (
    .clk(clk), .rst(rst), .frameStart(frameStart), .convDone(convDone),
    .convData(convData), .convStart(convStart), .muxSel(muxSel),
    .scanIdx(scanIdx), .results(results)
  );

  function automatic logic [15:0] slotOf(int k);
    return results[k*16 +: 16];
  endfunction

  task automatic check(string req, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  task automatic checkSlots(string req);
    for (int k = 0; k < NCH; k++) check(req, $sformatf("slot %0d", k), slotOf(k), model[k]);
  endtask

  task automatic pulseFrame();
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  // Emulated converter answering channel k after lat cycles.
  task automatic answer(int k, logic [9:0] data, int lat);
    repeat (lat) @(negedge clk);
    convDone = 1'b1;
    convData = data;
    @(negedge clk);
    convDone = 1'b0;
    model[k] = {6'b0, data};
    check("R4", "count after done", scanIdx, k + 1);
    check("R4", "slot written", slotOf(k), model[k]);
    check("R7", "slot upper bits", slotOf(k) >> 10, 0);
    if (k < NCH - 1) begin
      check("R5", "next mux", muxSel, k + 1);
      check("R5", "next start", convStart, 1);
    end else begin
      check("R6", "parked mux", muxSel, 0);
      check("R6", "count done", scanIdx, NCH);
      check("R6", "no start", convStart, 0);
    end
  endtask

  task automatic startFrame();
    pulseFrame();
    check("R2", "start pulse", convStart, 1);
    check("R2", "mux 0", muxSel, 0);
    check("R2", "count 0", scanIdx, 0);
    @(negedge clk);
    check("R3", "start width", convStart, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1; frameStart = 1'b0; convDone = 1'b0; convData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NCH; k++) model[k] = '0;
    check("R1", "count", scanIdx, 0);
    check("R1", "mux", muxSel, 0);
    check("R1", "start", convStart, 0);
    checkSlots("R1");
  endtask

  task automatic t_full_scan(logic [9:0] base);
    startFrame();
    for (int k = 0; k < NCH; k++) begin
      check("R10", "count before done", scanIdx, k);
      answer(k, base ^ 10'(k * 97 + 3), 1 + k);
    end
    repeat (4) begin
      @(negedge clk);
      check("R6", "idle no start", convStart, 0);
      check("R6", "idle mux", muxSel, 0);
    end
  endtask

  task automatic t_frame_during_scan();
    startFrame();
    answer(0, 10'h155, 2);
    @(negedge clk);
    pulseFrame();
    check("R8", "count kept", scanIdx, 1);
    check("R8", "mux kept", muxSel, 1);
    check("R8", "no start", convStart, 0);
    @(negedge clk);
    check("R8", "still no start", convStart, 0);
    for (int k = 1; k < NCH; k++) answer(k, 10'h2AA - 10'(k), 1);
  endtask

  task automatic t_done_while_idle();
    convDone = 1'b1; convData = 10'h3FF;
    @(negedge clk);
    convDone = 1'b0;
    @(negedge clk);
    check("R9", "count unchanged", scanIdx, NCH);
    check("R9", "no start", convStart, 0);
    checkSlots("R9");
  endtask

  task automatic t_retention();
    startFrame();
    checkSlots("R10");
    answer(0, 10'h3FF, 3);
    for (int k = 1; k < NCH; k++) check("R10", "old slot kept", slotOf(k), model[k]);
    check("R7", "full-scale slot", slotOf(0), 16'h03FF);
    for (int k = 1; k < NCH; k++) answer(k, 10'h000, 1);
  endtask

  initial begin
    t_reset();
    t_full_scan(10'h0A5);
    t_frame_during_scan();
    t_done_while_idle();
    t_retention();
    t_full_scan(10'h31C);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule